// File: doc/BRIEF.md
# Interrupt Pending and Arbitration Unit

This block gathers interrupt requests from a mix of sources and turns them into one serviced vector at a time. The sources are a reset request, a non-maskable rising-edge line, three external edge lines with a per-line polarity choice, one external line that can be set up as edge or level of either sense, an active-low level line shared with a UART request, and a set of on-chip peripheral request lines. Each vector owns one pending bit. Each source has its own rules for how its pending bit is set and cleared.

Maskable vectors reach the arbiter only when both their own enable bit and the global enable bit are set. Every cycle, a fixed-priority encoder presents a valid flag and the index of the winning vector. The CPU tells the block which vector it has taken through a separate acknowledge strobe. The acknowledge clears the pending bits that are cleared by hardware, and it also drops the global enable. Software reaches the enable, pending and condition registers through a simple write-strobe register port with combinational read data. The reset input is expected to arrive already synchronized to the clock.

Top module: `irq_arbiter`

## Requirements
- R1: After reset, the pending register (address 1), the enable register (address 0) and the condition register (address 2) all read zero, and `irq_valid` is low.
- R2: Vector 0 (reset request) cannot be masked and wins over every other vector. Its pending bit follows the synchronized `reset_req` level, and software writes do not change it.
- R3: Vector 1 is set by a rising edge on `nmi_in` and cannot be masked. Its pending bit is read-only to software. Acknowledging vector 1 clears it.
- R4: Vectors 2, 3 and 4 take `ext_in[0]`, `ext_in[1]` and `ext_in[2]`. Condition bit i set to 1 selects a rising edge and 0 selects a falling edge. A pending bit is set even while its vector is disabled.
- R5: In the pending register, writing 0 to bit 2, 3, 4 or 6 clears that bit and writing 1 leaves it unchanged. An acknowledge does not clear bits 2 to 4.
- R6: Vector 6 takes `ei_in` under condition bits [4:3]: 00 falling edge, 01 rising edge, 10 low level, 11 high level. An acknowledge of vector 6 clears its pending bit. In a level mode the bit is set again while the level stays active.
- R7: The pending bit of vector 5 is the level of a shared line. When `uart_rx_en` or `uart_tx_en` is high, that level is `uart_req` (active high). Otherwise it is the inverted `shared_n` line.
- R8: Peripheral vectors 7 and up are set while `periph_req[k]` is high. Software writes load them directly, so a write can set or clear them. An acknowledge never clears them.
- R9: A vector at index 2 or above is requested only when its enable bit and enable bit 0 (the global enable) are both 1. Enable bit 1 always reads 0.
- R10: `irq_valid` is high when any request is active, and `irq_vec` is then the lowest requesting index.
- R11: Every acknowledge clears the global enable bit. An acknowledge wins over a register write in the same cycle.
- R12: An edge on an external input is reflected in the pending register after the fourth rising clock edge following the input change. A hardware set wins over a software clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| reset_req | input | 1 | Reset interrupt request, active high |
| nmi_in | input | 1 | Non-maskable request line, rising edge |
| ext_in | input | 3 | External edge lines for vectors 2 to 4 |
| ei_in | input | 1 | Configurable external line for vector 6 |
| shared_n | input | 1 | Active-low external level line shared with the UART |
| uart_req | input | 1 | UART request, active high |
| uart_rx_en | input | 1 | UART receive interrupt enable |
| uart_tx_en | input | 1 | UART transmit interrupt enable |
| periph_req | input | NPERIPH | Peripheral request lines for vectors 7 and up |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 enable, 1 pending, 2 condition |
| reg_wdata | input | NVEC | Register write data |
| reg_rdata | output | NVEC | Register read data, combinational |
| ack | input | 1 | Service acknowledge strobe |
| ack_vec | input | VW | Index of the vector being serviced |
| irq_valid | output | 1 | Some request is active |
| irq_vec | output | VW | Index of the winning vector |

## Verification
The hardest state to reach from the ports is a request that sits pending while masked, and then shows up at the output only when software changes the enables. It has to be paired with acknowledges that must leave some pending bits untouched while clearing others and dropping the global enable. Directed sequences build that state step by step: an edge is driven with the vector disabled, the enables are opened one at a time, and the acknowledge is aimed at vectors whose bits must survive it. Level mode on the configurable input is held active across an acknowledge to show the bit being set again. A random phase then sweeps enable and peripheral pending patterns drawn from a fixed seed and compares the winner with a bench priority function.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    REG_EN   = 2'd0,
    REG_PEND = 2'd1,
    REG_COND = 2'd2,
    REG_NONE = 2'd3
  } irq_reg_e;

  localparam int VEC_RESET  = 0;
  localparam int VEC_NMI    = 1;
  localparam int VEC_X0     = 2;
  localparam int VEC_SHARED = 5;
  localparam int VEC_EI     = 6;
  localparam int VEC_PERIPH = 7;
  localparam int COND_W     = 5;
  localparam int EDGE_LINES = 5;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], din};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int N = 10,
  parameter int W = 4
) (
  input  logic [N-1:0] req,
  output logic         valid,
  output logic [W-1:0] vec
);
  always_comb begin
    valid = 1'b0;
    vec   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        valid = 1'b1;
        vec   = W'(i);
      end
    end
  end

  always_comb begin
    assert_grant_pending_R10: assert (!valid || req[vec]);
    assert_idle_when_empty_R10: assert ((req != '0) == valid);
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int NPERIPH = 3,
  parameter int SYNC_STAGES = 2,
  localparam int NVEC = VEC_PERIPH + NPERIPH,
  localparam int VW = $clog2(NVEC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reset_req,
  input  logic               nmi_in,
  input  logic [2:0]         ext_in,
  input  logic               ei_in,
  input  logic               shared_n,
  input  logic               uart_req,
  input  logic               uart_rx_en,
  input  logic               uart_tx_en,
  input  logic [NPERIPH-1:0] periph_req,
  input  logic               reg_wr,
  input  logic [1:0]         reg_addr,
  input  logic [NVEC-1:0]    reg_wdata,
  output logic [NVEC-1:0]    reg_rdata,
  input  logic               ack,
  input  logic [VW-1:0]      ack_vec,
  output logic               irq_valid,
  output logic [VW-1:0]      irq_vec
);
  // ---------------- input synchronizers ----------------
  logic [EDGE_LINES-1:0] eline_raw, eline_lvl, eline_prv_q;
  logic                  rst_lvl, shn_lvl;

  assign eline_raw = {ei_in, ext_in, nmi_in};

  for (genvar g = 0; g < EDGE_LINES; g++) begin : g_esync
    irq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(eline_raw[g]), .dout(eline_lvl[g]));
  end

  irq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rsync (
    .clk(clk), .rst_n(rst_n), .din(reset_req), .dout(rst_lvl));
  irq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_shsync (
    .clk(clk), .rst_n(rst_n), .din(shared_n), .dout(shn_lvl));

  // ---------------- edge / level detection ----------------
  logic [EDGE_LINES-1:0] rise, fall, set_d, set_q;
  logic [COND_W-1:0]     cond_q, cond_d;
  logic                  shared_lvl;

  always_comb begin
    rise = eline_lvl & ~eline_prv_q;
    fall = ~eline_lvl & eline_prv_q;
    set_d[0] = rise[0];
    for (int i = 0; i < 3; i++)
      set_d[i+1] = cond_q[i] ? rise[i+1] : fall[i+1];
    if (cond_q[4]) set_d[4] = (eline_lvl[4] == cond_q[3]);
    else           set_d[4] = cond_q[3] ? rise[4] : fall[4];
    shared_lvl = (uart_rx_en | uart_tx_en) ? uart_req : ~shn_lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eline_prv_q <= '0;
      set_q       <= '0;
    end else begin
      eline_prv_q <= eline_lvl;
      set_q       <= set_d;
    end
  end

  // ---------------- register file next state ----------------
  logic [NVEC-1:0] pend_q, pend_d, en_q, en_d, req;
  logic            wr_pend, wr_en, wr_cond, en_ce;

  assign wr_pend = reg_wr && (reg_addr == REG_PEND);
  assign wr_en   = reg_wr && (reg_addr == REG_EN);
  assign wr_cond = reg_wr && (reg_addr == REG_COND);
  assign en_ce   = wr_en || ack;

  always_comb begin
    pend_d = pend_q;
    if (ack && ack_vec == VW'(VEC_NMI)) pend_d[VEC_NMI] = 1'b0;
    if (ack && ack_vec == VW'(VEC_EI))  pend_d[VEC_EI]  = 1'b0;
    if (wr_pend) begin
      pend_d[VEC_X0+2:VEC_X0] = pend_q[VEC_X0+2:VEC_X0] & reg_wdata[VEC_X0+2:VEC_X0];
      pend_d[VEC_EI]          = pend_d[VEC_EI] & reg_wdata[VEC_EI];
      pend_d[NVEC-1:VEC_PERIPH] = reg_wdata[NVEC-1:VEC_PERIPH];
    end
    pend_d[VEC_NMI]             = pend_d[VEC_NMI] | set_q[0];
    pend_d[VEC_X0+2:VEC_X0]     = pend_d[VEC_X0+2:VEC_X0] | set_q[3:1];
    pend_d[VEC_EI]              = pend_d[VEC_EI] | set_q[4];
    pend_d[NVEC-1:VEC_PERIPH]   = pend_d[NVEC-1:VEC_PERIPH] | periph_req;
    pend_d[VEC_RESET]           = rst_lvl;
    pend_d[VEC_SHARED]          = shared_lvl;
  end

  always_comb begin
    en_d = en_q;
    if (wr_en) begin
      en_d    = reg_wdata;
      en_d[1] = 1'b0;
    end
    if (ack) en_d[0] = 1'b0;
    cond_d = reg_wdata[COND_W-1:0];
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_ce) en_q <= en_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cond_q <= '0;
    else if (wr_cond) cond_q <= cond_d;
  end

  // ---------------- read port ----------------
  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      REG_EN:   reg_rdata = en_q;
      REG_PEND: reg_rdata = pend_q;
      REG_COND: reg_rdata[COND_W-1:0] = cond_q;
      default:  reg_rdata = '0;
    endcase
  end

  // ---------------- masking and arbitration ----------------
  always_comb begin
    req = pend_q;
    for (int v = VEC_X0; v < NVEC; v++)
      req[v] = pend_q[v] & en_q[v] & en_q[0];
  end

  irq_prio_enc #(.N(NVEC), .W(VW)) u_enc (
    .req(req), .valid(irq_valid), .vec(irq_vec));

  // ---------------- assertions ----------------
  assert_reset_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q[VEC_RESET] |-> (irq_valid && irq_vec == VW'(VEC_RESET)));

  assert_nmi_readonly_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pend && !set_q[0] && !(ack && ack_vec == VW'(VEC_NMI)))
      |=> (pend_q[VEC_NMI] == $past(pend_q[VEC_NMI])));

  assert_ext_survive_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !wr_pend) |=> ((pend_q[4:2] & $past(pend_q[4:2])) == $past(pend_q[4:2])));

  assert_mask_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_vec >= VW'(VEC_X0)) |-> (en_q[0] && en_q[irq_vec]));

  assert_gie_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !en_q[0]);

  assert_periph_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_pend |=> ((pend_q[NVEC-1:VEC_PERIPH] & $past(pend_q[NVEC-1:VEC_PERIPH]))
                  == $past(pend_q[NVEC-1:VEC_PERIPH])));
endmodule

// File: tb/irq_arbiter_test.sv
`timescale 1ns/1ps
module irq_arbiter_test;
  localparam int NPERIPH = 3;
  localparam int NVEC = 7 + NPERIPH;
  localparam int VW = $clog2(NVEC);

  logic clk = 1'b0;
  logic rst_n, reset_req, nmi_in, ei_in, shared_n, uart_req, uart_rx_en, uart_tx_en;
  logic [2:0] ext_in;
  logic [NPERIPH-1:0] periph_req;
  logic reg_wr, ack;
  logic [1:0] reg_addr;
  logic [NVEC-1:0] reg_wdata, reg_rdata;
  logic [VW-1:0] ack_vec, irq_vec;
  logic irq_valid;
  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  irq_arbiter #(.NPERIPH(NPERIPH)) uut (
    .clk(clk), .rst_n(rst_n), .reset_req(reset_req), .nmi_in(nmi_in), .ext_in(ext_in),
    .ei_in(ei_in), .shared_n(shared_n), .uart_req(uart_req), .uart_rx_en(uart_rx_en),
    .uart_tx_en(uart_tx_en), .periph_req(periph_req), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ack(ack), .ack_vec(ack_vec),
    .irq_valid(irq_valid), .irq_vec(irq_vec));

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    $display("FAIL watchdog all actual=hung expected=finished");
    summary();
    $finish;
  end

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int addr, input int data);
    reg_addr = 2'(addr); reg_wdata = NVEC'(data); reg_wr = 1'b1;
    step(1);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int addr, output int v);
    reg_addr = 2'(addr); #0.5;
    v = int'(reg_rdata);
  endtask

  task automatic do_ack(input int v);
    ack = 1'b1; ack_vec = VW'(v);
    step(1);
    ack = 1'b0;
  endtask

  function automatic int exp_irq(input int pend, input int en);
    for (int v = 0; v < NVEC; v++) begin
      if (v < 2) begin
        if (pend[v]) return v;
      end else if (pend[v] && en[v] && en[0]) return v;
    end
    return -1;
  endfunction

  function automatic int got_irq();
    return irq_valid ? int'(irq_vec) : -1;
  endfunction

  int v;

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; reset_req = 0; nmi_in = 0; ext_in = 3'b000; ei_in = 0; shared_n = 1;
    uart_req = 0; uart_rx_en = 0; uart_tx_en = 0; periph_req = '0;
    reg_wr = 0; reg_addr = 0; reg_wdata = '0; ack = 0; ack_vec = '0;
    step(3);
    rst_n = 1'b1;
    step(2);

    // R1 reset state
    rd(1, v); chk("R1 pending", v, 0);
    rd(0, v); chk("R1 enable", v, 0);
    rd(2, v); chk("R1 cond", v, 0);
    chk("R1 irq_valid", int'(irq_valid), 0);

    // R12 latency and R3 NMI
    nmi_in = 1'b1;
    step(3); rd(1, v); chk("R12 not yet pending", v, 0);
    step(1); rd(1, v); chk("R12 pending at 4th edge", v, 'h002);
    chk("R3 nmi unmaskable", got_irq(), 1);
    wr(1, 0); rd(1, v); chk("R3 nmi read-only", v, 'h002);
    do_ack(1); rd(1, v); chk("R3 nmi ack clear", v, 0);

    // R4 polarity, set while disabled
    wr(2, 'b00001);
    ext_in = 3'b111; step(6); rd(1, v); chk("R4 rising on x0 only", v, 'h004);
    chk("R9 disabled no request", got_irq(), -1);
    ext_in = 3'b000; step(6); rd(1, v); chk("R4 falling on x1 x2", v, 'h01C);

    // R9 / R10
    wr(0, 'h009); chk("R9 only enabled wins", got_irq(), 3);
    wr(0, 'h01D); chk("R10 lowest index", got_irq(), 2);

    // R11 ack drops global enable; R5 ack keeps ext bits
    do_ack(2);
    rd(0, v); chk("R11 gie cleared", v, 'h01C);
    chk("R11 no request after ack", got_irq(), -1);
    rd(1, v); chk("R5 ack keeps ext pending", v, 'h01C);

    // R5 write zero clears, one no effect
    wr(1, 'h077); rd(1, v); chk("R5 write zero clears", v, 'h014);
    wr(1, 'h07F); rd(1, v); chk("R5 write one no effect", v, 'h014);

    // R6 EI modes
    wr(2, 'b11001);
    ei_in = 1'b1; step(6); rd(1, v); chk("R6 high level sets", v, 'h054);
    do_ack(6); rd(1, v); chk("R6 level resets after ack", v, 'h054);
    ei_in = 1'b0; step(6); do_ack(6); rd(1, v); chk("R6 ack clears", v, 'h014);
    wr(2, 'b01001);
    ei_in = 1'b1; step(6); rd(1, v); chk("R6 rising edge sets", v, 'h054);
    do_ack(6); rd(1, v); chk("R6 edge cleared by ack", v, 'h014);

    // R7 shared line
    shared_n = 1'b0; step(5); rd(1, v); chk("R7 external low level", v, 'h034);
    uart_rx_en = 1'b1; step(4); rd(1, v); chk("R7 uart selected idle", v, 'h014);
    uart_req = 1'b1; step(4); rd(1, v); chk("R7 uart request", v, 'h034);
    uart_req = 1'b0; uart_rx_en = 1'b0; shared_n = 1'b1; step(5);
    rd(1, v); chk("R7 released", v, 'h014);

    // R8 peripherals
    periph_req = 3'b001; step(1); periph_req = '0; step(1);
    rd(1, v); chk("R8 periph set", v, 'h094);
    do_ack(7); rd(1, v); chk("R8 ack keeps periph", v, 'h094);
    wr(1, 'h07F); rd(1, v); chk("R8 software clear", v, 'h014);
    wr(1, 'h17F); rd(1, v); chk("R8 software set", v, 'h114);

    // R2 reset request
    wr(0, 'h3FD);
    reset_req = 1'b1; step(5);
    chk("R2 reset wins", got_irq(), 0);
    wr(1, 'h17E); rd(1, v); chk("R2 reset bit read-only", v, 'h115);
    reset_req = 1'b0; step(5);
    chk("R10 after reset release", got_irq(), 2);

    // R12 set beats clear
    periph_req = 3'b100; wr(1, 'h07F); periph_req = '0;
    rd(1, v); chk("R12 set beats clear", v, 'h214);

    // random phase
    wr(1, 0); rd(1, v); chk("R8 cleared for random", v, 0);
    for (int i = 0; i < 40; i++) begin
      int r, e, pv;
      r = int'($urandom); e = int'($urandom) & 'h3FD; pv = r & 7;
      wr(0, e);
      wr(1, (pv << 7) | ((r >> 3) & 'h7F));
      rd(1, v); chk("R5 R8 random pending", v, pv << 7);
      chk("R9 R10 random winner", got_irq(), exp_irq(pv << 7, e));
    end

    summary();
    $finish;
  end
endmodule